// File: doc/BRIEF.md
# Programmable PRBS and Repeating-Word Test Pattern Generator

This block is the transmit-side source of a bit-error-rate tester. Each cycle in which the bit enable is high and the generator is switched on, it shifts out one serial test bit. The bit comes from one of two sources. The first is a pseudo-random sequence from a feedback polynomial x^n + x^y + 1, where the length n and the tap y are set at run time. The second is a word of n bits that repeats.

The starting contents of the shift register come from a seed input. The seed is copied in by a load strobe, and only while the generator is enabled. A load strobe while the generator is disabled is ignored.

An error-insertion unit can invert chosen output bits. It can invert one bit on a single request, one bit for every edge of an external pin, or one bit in every 10^k emitted bits. All configuration arrives on plain register-style inputs.

Top module: `prbs_patgen`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `data_out` and `data_valid` are 0. The shift register and all pending error state are cleared.
- R2: An emission happens in a cycle with `gen_enable`=1, `bit_en`=1 and `load_strobe`=0. `data_valid` is high in exactly the cycle after an emission. When no emission happens, `data_out` holds its value.
- R3: If `load_strobe`=1 while `gen_enable`=1, the register takes `seed_cfg` with every bit at or above position n cleared. In that cycle no bit is emitted, whatever the value of `bit_en`.
- R4: A `load_strobe` while `gen_enable`=0 leaves the register unchanged. After re-enabling, the sequence carries on from where it stopped.
- R5: PRBS mode (`mode_sel`=0): the emitted bit is register bit n-1, numbering from 0. The register then shifts left by one. The new bit 0 is bit(n-1) XOR bit(y-1), and bits n and above stay 0.
- R6: In PRBS mode an all-zero seed keeps the output at 0 for good. The block does not replace the seed.
- R7: Repeat mode (`mode_sel`=1): the low n bits rotate left by one per emission, and bit n-1 is emitted. The word therefore comes out MSB first with a period of n bits.
- R8: A one-cycle `err_single` pulse inverts exactly one emitted bit. That bit is the first emission on or after the next rising edge.
- R9: Every edge of `err_pin`, rising or falling, inverts exactly one emitted bit. The pin passes through a two-flop synchroniser, so a change sampled at one edge affects emissions from the third rising edge onwards. A single request and a pin edge that are still pending together invert only one bit.
- R10: While `rate_en`=1, one emitted bit in every 10^k is inverted. The first inverted bit is the 10^k-th emission after `rate_en` rises. A `rate_exp` of 0 is treated as k=1.
- R11: A `len_cfg` of 0 or above 32 means n=32. A `tap_cfg` of 0 means y=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_enable | input | 1 | Generator on; also gates seed loads |
| bit_en | input | 1 | Clock enable, one bit per asserted cycle |
| mode_sel | input | 1 | 0 = PRBS, 1 = repeating word |
| len_cfg | input | 6 | Register length n (1..32) |
| tap_cfg | input | 6 | Feedback tap y (1..n-1) |
| seed_cfg | input | 32 | Seed or repeating word |
| load_strobe | input | 1 | Copy seed into register |
| err_single | input | 1 | Request one inverted bit |
| err_pin | input | 1 | Asynchronous error-insertion pin |
| rate_en | input | 1 | Enable decimal-rate injection |
| rate_exp | input | 3 | Exponent k of the rate 1/10^k |
| data_out | output | 1 | Registered serial test bit |
| data_valid | output | 1 | High in the cycle after an emission |

## Verification
`data_out` and `data_valid` arrive one rising edge after the cycle in which the emission conditions hold.

Injection has different delays for each source:
- A single request counts from the edge after its pulse.
- A pin change counts from the third edge after it is sampled, because of the synchroniser and the edge detector.
- Rate injection is tied to the emission count, not to the cycle count.

The bench carries these delays in a behavioural model that steps on each rising edge using the same input values the design sees. The bench drives inputs on falling edges and compares the outputs with the model on every falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/prbs_patgen_pkg.sv
`timescale 1ns/1ps
package prbs_patgen_pkg;

  typedef enum logic {
    PAT_PRBS   = 1'b0,
    PAT_REPEAT = 1'b1
  } pat_mode_e;

  // 10 raised to k, for the rate injector reload values
  function automatic int unsigned pow10(input int unsigned k);
    int unsigned r;
    r = 1;
    for (int i = 0; i < 10; i++) begin
      if (i < int'(k)) r = r * 10;
    end
    return r;
  endfunction

endpackage

// File: rtl/patgen_sreg.sv
`timescale 1ns/1ps
module patgen_sreg
  import prbs_patgen_pkg::*;
#(
  parameter int W  = 32,
  localparam int LW = $clog2(W + 1),
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          advance,
  input  pat_mode_e     mode,
  input  logic [LW-1:0] len_cfg,
  input  logic [LW-1:0] tap_cfg,
  input  logic [W-1:0]  seed,
  output logic          msb_bit
);

  logic [W-1:0]  state;
  logic [W-1:0]  mask;
  logic [W-1:0]  shifted;
  logic [LW-1:0] n_eff;
  logic [IW-1:0] top_idx;
  logic [IW-1:0] tap_idx;
  logic          fb;

  // Out-of-range length or tap values are clamped
  always_comb begin
    if (len_cfg == '0 || len_cfg > LW'(W)) n_eff = LW'(W);
    else                                   n_eff = len_cfg;
    top_idx = IW'(n_eff - 1'b1);
    if (tap_cfg == '0)          tap_idx = '0;
    else if (tap_cfg > LW'(W))  tap_idx = IW'(W - 1);
    else                        tap_idx = IW'(tap_cfg - 1'b1);
  end

  // One mask bit per active stage
  for (genvar g = 0; g < W; g++) begin : g_mask
    assign mask[g] = (LW'(g) < n_eff);
  end

  always_comb begin
    msb_bit = state[top_idx];
    fb      = (mode == PAT_REPEAT) ? msb_bit : (msb_bit ^ state[tap_idx]);
    shifted = ({state[W-2:0], 1'b0} | W'(fb)) & mask;
  end

  always_ff @(posedge clk) begin
    if (rst)          state <= '0;
    else if (load)    state <= seed & mask;
    else if (advance) state <= shifted;
  end

endmodule

// File: rtl/patgen_pin_sync.sv
`timescale 1ns/1ps
module patgen_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic pin_edge
);

  // chain[0..STAGES-1] synchronise, chain[STAGES] holds the previous level
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], pin_async};
  end

  assign pin_edge = chain[STAGES] ^ chain[STAGES-1];

endmodule

// File: rtl/patgen_err_inject.sv
`timescale 1ns/1ps
module patgen_err_inject
  import prbs_patgen_pkg::*;
#(
  parameter int KMAX = 7,
  localparam int KW = $clog2(KMAX + 1),
  localparam int CW = $clog2(pow10(KMAX))
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          emit,
  input  logic          single_req,
  input  logic          pin_edge,
  input  logic          rate_en,
  input  logic [KW-1:0] rate_exp,
  output logic          flip,
  output logic          pend
);

  logic [CW-1:0] reload_tbl [0:KMAX];
  logic [CW-1:0] reload_val;
  logic [CW-1:0] cnt;
  logic [KW-1:0] k_sel;
  logic          rate_hit;

  // Reload value per exponent; exponent 0 behaves as 1
  for (genvar g = 0; g <= KMAX; g++) begin : g_reload
    assign reload_tbl[g] = CW'(pow10((g == 0) ? 1 : g) - 1);
  end

  always_comb begin
    if (int'(rate_exp) > KMAX) k_sel = KW'(KMAX);
    else                       k_sel = rate_exp;
    reload_val = reload_tbl[k_sel];
    rate_hit   = rate_en && (cnt == '0);
    flip       = emit && (pend || rate_hit);
  end

  // One pending flag shared by the single-request and pin sources
  always_ff @(posedge clk) begin
    if (rst)                          pend <= 1'b0;
    else if (single_req || pin_edge)  pend <= 1'b1;
    else if (emit)                    pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (!rate_en) cnt <= reload_val;
    else if (emit) begin
      if (cnt == '0)   cnt <= reload_val;
      else             cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/prbs_patgen.sv
`timescale 1ns/1ps
module prbs_patgen
  import prbs_patgen_pkg::*;
#(
  parameter int W           = 32,
  parameter int KMAX        = 7,
  parameter int SYNC_STAGES = 2,
  localparam int LW = $clog2(W + 1),
  localparam int KW = $clog2(KMAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gen_enable,
  input  logic          bit_en,
  input  logic          mode_sel,
  input  logic [LW-1:0] len_cfg,
  input  logic [LW-1:0] tap_cfg,
  input  logic [W-1:0]  seed_cfg,
  input  logic          load_strobe,
  input  logic          err_single,
  input  logic          err_pin,
  input  logic          rate_en,
  input  logic [KW-1:0] rate_exp,
  output logic          data_out,
  output logic          data_valid
);

  logic load_ok;
  logic emit;
  logic msb_bit;
  logic flip;
  logic pend_w;
  logic pin_edge_w;

  assign load_ok = gen_enable && load_strobe;
  assign emit    = gen_enable && bit_en && !load_strobe;

  patgen_sreg #(.W(W)) u_sreg (
    .clk     (clk),
    .rst     (rst),
    .load    (load_ok),
    .advance (emit),
    .mode    (pat_mode_e'(mode_sel)),
    .len_cfg (len_cfg),
    .tap_cfg (tap_cfg),
    .seed    (seed_cfg),
    .msb_bit (msb_bit)
  );

  patgen_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk       (clk),
    .rst       (rst),
    .pin_async (err_pin),
    .pin_edge  (pin_edge_w)
  );

  patgen_err_inject #(.KMAX(KMAX)) u_inj (
    .clk        (clk),
    .rst        (rst),
    .emit       (emit),
    .single_req (err_single),
    .pin_edge   (pin_edge_w),
    .rate_en    (rate_en),
    .rate_exp   (rate_exp),
    .flip       (flip),
    .pend       (pend_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out   <= 1'b0;
      data_valid <= 1'b0;
    end else begin
      data_valid <= emit;
      if (emit) data_out <= msb_bit ^ flip;
    end
  end

endmodule

// File: rtl/prbs_patgen_chk.sv
`timescale 1ns/1ps
module prbs_patgen_chk (
  input logic clk,
  input logic rst,
  input logic gen_enable,
  input logic bit_en,
  input logic load_strobe,
  input logic err_single,
  input logic data_out,
  input logic data_valid,
  input logic pend,
  input logic pin_edge
);

  a_r2_valid_after_emit: assert property (@(posedge clk) disable iff (rst)
    (gen_enable && bit_en && !load_strobe) |=> data_valid);

  a_r2_no_valid_when_idle: assert property (@(posedge clk) disable iff (rst)
    !(gen_enable && bit_en && !load_strobe) |=> !data_valid);

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !data_valid |-> $stable(data_out));

  a_r8_request_sets_pending: assert property (@(posedge clk) disable iff (rst)
    err_single |=> pend);

  a_r8_pending_consumed: assert property (@(posedge clk) disable iff (rst)
    (pend && gen_enable && bit_en && !load_strobe && !err_single && !pin_edge)
      |=> !pend);

endmodule

bind prbs_patgen prbs_patgen_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .gen_enable  (gen_enable),
  .bit_en      (bit_en),
  .load_strobe (load_strobe),
  .err_single  (err_single),
  .data_out    (data_out),
  .data_valid  (data_valid),
  .pend        (pend_w),
  .pin_edge    (pin_edge_w)
);

// File: tb/prbs_patgen_tb_top.sv
`timescale 1ns/1ps
module prbs_patgen_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gen_enable = 1'b0;
  logic        bit_en = 1'b0;
  logic        mode_sel = 1'b0;
  logic [5:0]  len_cfg = 6'd7;
  logic [5:0]  tap_cfg = 6'd6;
  logic [31:0] seed_cfg = 32'h0;
  logic        load_strobe = 1'b0;
  logic        err_single = 1'b0;
  logic        err_pin = 1'b0;
  logic        rate_en = 1'b0;
  logic [2:0]  rate_exp = 3'd1;
  logic        data_out;
  logic        data_valid;

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R1";
  bit    gating = 1'b0;
  bit    done   = 1'b0;

  always #2.5 clk = ~clk;

  prbs_patgen dut_i (
    .clk(clk), .rst(rst), .gen_enable(gen_enable), .bit_en(bit_en),
    .mode_sel(mode_sel), .len_cfg(len_cfg), .tap_cfg(tap_cfg),
    .seed_cfg(seed_cfg), .load_strobe(load_strobe), .err_single(err_single),
    .err_pin(err_pin), .rate_en(rate_en), .rate_exp(rate_exp),
    .data_out(data_out), .data_valid(data_valid)
  );

  // Behavioural reference model, stepped on each rising edge
  logic [31:0] m_sr;
  bit m_out, m_val, m_pend, p1, p2, p3;
  int m_cnt;
  int n, y, keff, reload;
  bit emit, pedge, msb, inj, fb;

  function automatic logic [31:0] mk(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
  endfunction

  function automatic int p10(input int k);
    int r = 1;
    for (int i = 0; i < k; i++) r = r * 10;
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sr = 0; m_out = 0; m_val = 0; m_pend = 0; m_cnt = 0;
      p1 = 0; p2 = 0; p3 = 0;
    end else begin
      n      = (len_cfg == 0 || len_cfg > 32) ? 32 : int'(len_cfg);
      y      = (tap_cfg == 0) ? 1 : int'(tap_cfg);
      keff   = (rate_exp == 0) ? 1 : int'(rate_exp);
      reload = p10(keff) - 1;
      emit   = gen_enable && bit_en && !load_strobe;
      pedge  = p2 ^ p3;
      msb    = m_sr[n-1];
      inj    = m_pend || (rate_en && m_cnt == 0);
      m_val  = emit;
      if (emit) m_out = msb ^ inj;
      if (gen_enable && load_strobe) m_sr = seed_cfg & mk(n);
      else if (emit) begin
        fb   = mode_sel ? msb : (msb ^ m_sr[y-1]);
        m_sr = ((m_sr << 1) | {31'b0, fb}) & mk(n);
      end
      if (err_single || pedge) m_pend = 1;
      else if (emit)           m_pend = 0;
      if (!rate_en) m_cnt = reload;
      else if (emit) m_cnt = (m_cnt == 0) ? reload : m_cnt - 1;
      p3 = p2; p2 = p1; p1 = err_pin;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (data_out !== m_out || data_valid !== m_val) begin
        fails++;
        $display("FAIL %s: data_out=%0b data_valid=%0b expected %0b %0b",
                 tag, data_out, data_valid, m_out, m_val);
      end
    end
  end

  // Randomised bit enable when gating is on
  always @(negedge clk) bit_en = gating ? (($urandom % 4) != 0) : 1'b1;

  task automatic run(input int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  task automatic load(input bit m, input int len, input int tap, input logic [31:0] s);
    @(negedge clk);
    mode_sel = m; len_cfg = 6'(len); tap_cfg = 6'(tap); seed_cfg = s;
    load_strobe = 1'b1;
    @(negedge clk);
    load_strobe = 1'b0;
  endtask

  task automatic note(input string r, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (4) @(negedge clk);
    note("R1", data_out == 0 && data_valid == 0, int'(data_out), 0);
    rst = 1'b0;
    @(negedge clk);
    note("R1", data_valid == 0, int'(data_valid), 0);

    tag = "R5"; gen_enable = 1'b1; gating = 1'b1;
    load(0, 7, 6, 32'h7F);           run(300);
    load(0, 23, 18, 32'h1);          run(300);
    load(0, 15, 14, 32'h1234);       run(200);
    tag = "R3"; gating = 1'b0;
    load(0, 32, 22, 32'hDEAD_BEEF);  run(200);
    gating = 1'b1;
    tag = "R11"; load(0, 0, 0, 32'hCAFE_0001); run(150);

    tag = "R7";
    load(1, 8, 1, 32'hA5);           run(120);
    load(1, 1, 1, 32'h1);            run(40);
    load(1, 32, 1, 32'h8000_0F0F);   run(150);
    load(1, 5, 1, 32'hFFFF_FFF3);    run(60);

    tag = "R4";
    gen_enable = 1'b0; run(3);
    mode_sel = 1'b1; seed_cfg = 32'h3C; load_strobe = 1'b1;
    @(negedge clk); load_strobe = 1'b0; run(5);
    gen_enable = 1'b1; run(80);

    tag = "R6";
    load(0, 9, 5, 32'h0); run(100);
    note("R6", data_out == 0, int'(data_out), 0);

    tag = "R8";
    load(0, 7, 6, 32'h55);
    for (int i = 0; i < 6; i++) begin
      run(17 + i);
      err_single = 1'b1; @(negedge clk); err_single = 1'b0;
    end
    run(40);

    tag = "R9";
    for (int i = 0; i < 6; i++) begin
      run(11 + 2 * i);
      err_pin = ~err_pin;
    end
    run(3);
    err_single = 1'b1; err_pin = ~err_pin;
    @(negedge clk); err_single = 1'b0;
    run(40);

    tag = "R10";
    rate_exp = 3'd1; rate_en = 1'b1; run(250);
    rate_en = 1'b0; rate_exp = 3'd2; run(3);
    rate_en = 1'b1; run(700);
    rate_en = 1'b0; rate_exp = 3'd0; run(3);
    rate_en = 1'b1; gating = 1'b0; run(80);
    rate_en = 1'b0; run(10);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule